// File: doc/BRIEF.md
# Station Address Table Loader

This block fills a small table of 48-bit station addresses from descriptors held in system memory. Software supplies a descriptor pointer, an entry count, a slot-width setting and a byte-order setting, then pulses a start request. The block walks the descriptors with halfword reads on a one-outstanding memory request/response port. For each descriptor it assembles a six-byte address and writes it into the table slot that the descriptor names. It then reads one final field, keeps it as the 16-bit table-enable mask, and pulses done.

Each descriptor field sits in a slot that is one halfword wide (narrow mode) or two halfwords wide (wide mode). In big-endian wide mode the useful halfword is the upper one of each slot. The table contents can be read back through a combinational lookup port.

Top module: `station_table_loader`

## Requirements
- R1: After reset `busy`, `donePulse` and `memReq` are 0, `enableMask` is 0 and every table entry reads back as 0.
- R2: With W = 1 (`wideSlots` = 0) or W = 2 (`wideSlots` = 1), field k of the descriptor at halfword address P is read from address P + k*W when `bigOrder` = 0, and its value is the returned halfword unchanged.
- R3: When `bigOrder` = 1, field k is read from address P + k*W + (W - 1) and its value is the returned halfword with its two bytes swapped (`memRespData[7:0]` becomes bits 15:8).
- R4: Field 0 of an entry descriptor is the table index; fields 1, 2 and 3 carry address bytes low byte first, so `lookupAddr[15:0]`, `[31:16]` and `[47:32]` equal the values of fields 1, 2 and 3.
- R5: Entry e (counting from 0) is read at descriptor address `descPtr` + 4*W*e, and exactly `entryCount` entries are read, fields in order 0 to 3.
- R6: After the last entry the mask is read as field 0 at `descPtr` + 4*W*`entryCount` and appears on `enableMask`; with `entryCount` = 0 only this read is made. The mask changes at no other time.
- R7: An entry whose index is 16 or more changes no table entry.
- R8: `donePulse` is high for exactly one cycle after the mask arrives, and in the next cycle `busy` is 0.
- R9: A start request while `busy` is 1 is ignored: the running load completes with its own pointer and count.
- R10: `memReq` is a one-cycle pulse and no new request is issued before the response to the previous one.
- R11: `wideSlots` and `bigOrder` are sampled at the accepted start; changing them during a load has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, accepted only when idle |
| descPtr | input | 16 | Halfword address of the first descriptor |
| entryCount | input | 8 | Number of entry descriptors |
| wideSlots | input | 1 | 1: two-halfword slots, 0: one-halfword slots |
| bigOrder | input | 1 | 1: big-endian field layout |
| memReq | output | 1 | One-cycle halfword read request |
| memAddr | output | 16 | Halfword read address, valid with memReq |
| memRespValid | input | 1 | Read data valid |
| memRespData | input | 16 | Read data; bits 7:0 are the byte at the even address |
| lookupIdx | input | 4 | Table slot to read back |
| lookupAddr | output | 48 | Station address in the selected slot |
| enableMask | output | 16 | Table-enable mask from the last load |
| busy | output | 1 | A load is in progress |
| donePulse | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the memory answers every request with exactly one `memRespValid` pulse and never sends a response without a request; the bench memory model always replies two cycles after each request and never otherwise. They also assume reset is held for at least one clock, which the bench does before any stimulus. Start pulses are only driven from the negative edge, and a second start is deliberately placed while a load runs, together with a change of the width and order inputs, to exercise the ignore paths.

// File: rtl/loader_pkg.sv
package loader_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_REQ, S_WAIT, S_WRITE, S_MREQ, S_MWAIT, S_DONE
  } loadState_t;

  typedef struct packed {
    logic       start;
    logic       req;
    logic       capture;
    logic       writeEntry;
    logic       storeMask;
    logic [1:0] fieldSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/loader_ctrl.sv
module loader_ctrl
  import loader_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         memRespValid,
  input  logic         countZero,
  output ctrlStrobes_t strb,
  output logic         memReq,
  output logic         busy,
  output logic         donePulse
);
  loadState_t state, stateNext;
  logic [1:0] fieldIdx;

  always_comb begin
    stateNext = state;
    strb = '0;
    strb.fieldSel = fieldIdx;
    case (state)
      S_IDLE: if (startReq) begin
        strb.start = 1'b1;
        stateNext = S_CHECK;
      end
      S_CHECK: stateNext = countZero ? S_MREQ : S_REQ;
      S_REQ: begin
        strb.req = 1'b1;
        stateNext = S_WAIT;
      end
      S_WAIT: if (memRespValid) begin
        strb.capture = 1'b1;
        stateNext = (fieldIdx == 2'd3) ? S_WRITE : S_REQ;
      end
      S_WRITE: begin
        strb.writeEntry = 1'b1;
        stateNext = S_CHECK;
      end
      S_MREQ: begin
        strb.req = 1'b1;
        strb.fieldSel = 2'd0;
        stateNext = S_MWAIT;
      end
      S_MWAIT: if (memRespValid) begin
        strb.storeMask = 1'b1;
        stateNext = S_DONE;
      end
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      fieldIdx <= 2'd0;
    end else begin
      state <= stateNext;
      if (strb.start) fieldIdx <= 2'd0;
      else if (strb.capture) fieldIdx <= fieldIdx + 2'd1;
    end
  end

  assign memReq = strb.req;
  assign busy = (state != S_IDLE);
  assign donePulse = (state == S_DONE);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> (!donePulse && !busy));

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
endmodule

// File: rtl/loader_datapath.sv
module loader_datapath
  import loader_pkg::*;
#(
  parameter int AddrW = 16,
  parameter int CountW = 8,
  parameter int NumEntries = 16,
  localparam int IdxW = $clog2(NumEntries),
  localparam int StationW = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic [AddrW-1:0]    descPtr,
  input  logic [CountW-1:0]   entryCount,
  input  logic                wideSlots,
  input  logic                bigOrder,
  input  logic [15:0]         memRespData,
  input  logic [IdxW-1:0]     lookupIdx,
  output logic [AddrW-1:0]    memAddr,
  output logic                countZero,
  output logic [StationW-1:0] lookupAddr,
  output logic [15:0]         enableMask
);
  logic [AddrW-1:0]  basePtr;
  logic [CountW-1:0] remaining;
  logic              wideR, bigR;
  logic [15:0]       idxReg, word1, word2, word3;
  logic [15:0]       fieldVal;
  logic [15:0]       maskReg;
  logic [StationW-1:0] tableArr [NumEntries];

  // Slot offset and byte order, fixed for the whole load
  assign memAddr = basePtr + (AddrW'(strb.fieldSel) << wideR) + AddrW'(wideR & bigR);
  assign fieldVal = bigR ? {memRespData[7:0], memRespData[15:8]} : memRespData;
  assign countZero = (remaining == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      basePtr <= '0;
      remaining <= '0;
      wideR <= 1'b0;
      bigR <= 1'b0;
    end else if (strb.start) begin
      basePtr <= descPtr;
      remaining <= entryCount;
      wideR <= wideSlots;
      bigR <= bigOrder;
    end else if (strb.writeEntry) begin
      basePtr <= basePtr + (wideR ? AddrW'(8) : AddrW'(4));
      remaining <= remaining - CountW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg <= '0;
      word1 <= '0;
      word2 <= '0;
      word3 <= '0;
    end else if (strb.capture) begin
      case (strb.fieldSel)
        2'd0: idxReg <= fieldVal;
        2'd1: word1 <= fieldVal;
        2'd2: word2 <= fieldVal;
        default: word3 <= fieldVal;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskReg <= '0;
    else if (strb.storeMask) maskReg <= fieldVal;
  end
  assign enableMask = maskReg;

  for (genvar g = 0; g < NumEntries; g++) begin : gSlot
    logic hit;
    assign hit = (idxReg == 16'(g));
    always_ff @(posedge clk) begin
      if (!rstN) tableArr[g] <= '0;
      else if (strb.writeEntry && hit) tableArr[g] <= {word3, word2, word1};
    end

    assert_bad_index_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
      (strb.writeEntry && (idxReg >= 16'(NumEntries))) |=> $stable(tableArr[g]));
  end

  assign lookupAddr = tableArr[lookupIdx];

  assert_mask_only_on_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.storeMask |=> $stable(maskReg));

  assert_count_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.start && !strb.writeEntry) |=> $stable(remaining));

  assert_mode_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.start |=> ($stable(wideR) && $stable(bigR)));
endmodule

// File: rtl/station_table_loader.sv
module station_table_loader
  import loader_pkg::*;
#(
  parameter int AddrW = 16,
  parameter int CountW = 8,
  parameter int NumEntries = 16,
  localparam int IdxW = $clog2(NumEntries)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [AddrW-1:0]  descPtr,
  input  logic [CountW-1:0] entryCount,
  input  logic              wideSlots,
  input  logic              bigOrder,
  output logic              memReq,
  output logic [AddrW-1:0]  memAddr,
  input  logic              memRespValid,
  input  logic [15:0]       memRespData,
  input  logic [IdxW-1:0]   lookupIdx,
  output logic [47:0]       lookupAddr,
  output logic [15:0]       enableMask,
  output logic              busy,
  output logic              donePulse
);
  ctrlStrobes_t strb;
  logic countZero;

  loader_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .memRespValid(memRespValid),
    .countZero(countZero), .strb(strb), .memReq(memReq), .busy(busy),
    .donePulse(donePulse)
  );

  loader_datapath #(.AddrW(AddrW), .CountW(CountW), .NumEntries(NumEntries)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .descPtr(descPtr), .entryCount(entryCount),
    .wideSlots(wideSlots), .bigOrder(bigOrder), .memRespData(memRespData),
    .lookupIdx(lookupIdx), .memAddr(memAddr), .countZero(countZero),
    .lookupAddr(lookupAddr), .enableMask(enableMask)
  );
endmodule

// File: tb/sim_station_table_loader.sv
module sim_station_table_loader;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, startReq, wideSlots, bigOrder, memReq, memRespValid, busy, donePulse;
  logic [15:0] descPtr, memAddr, memRespData, enableMask;
  logic [7:0]  entryCount;
  logic [3:0]  lookupIdx;
  logic [47:0] lookupAddr;

  station_table_loader u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .descPtr(descPtr), .entryCount(entryCount),
    .wideSlots(wideSlots), .bigOrder(bigOrder), .memReq(memReq), .memAddr(memAddr),
    .memRespValid(memRespValid), .memRespData(memRespData), .lookupIdx(lookupIdx),
    .lookupAddr(lookupAddr), .enableMask(enableMask), .busy(busy), .donePulse(donePulse)
  );

  int errors = 0, checks = 0;
  logic [15:0] mem [0:1023];
  logic [15:0] reqLog [0:127];
  int reqN = 0, protoErr = 0, pendCnt = 0;
  logic [15:0] pendAddr;
  logic [47:0] expTable [0:15];
  logic [15:0] expMask;
  int planIdx [0:7];
  logic [47:0] planAddr [0:7];

  // Memory model: one reply two cycles after each request
  always @(posedge clk) begin
    memRespValid <= 1'b0;
    if (pendCnt > 0) begin
      if (pendCnt == 1) begin
        memRespValid <= 1'b1;
        memRespData <= mem[pendAddr[9:0]];
      end
      pendCnt <= pendCnt - 1;
    end
    if (rstN && memReq) begin
      if (pendCnt != 0) protoErr = protoErr + 1;
      pendCnt <= 2;
      pendAddr <= memAddr;
      reqLog[reqN & 127] = memAddr;
      reqN = reqN + 1;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic putField(int base, int k, logic [15:0] v, bit wide, bit big);
    int w = wide ? 2 : 1;
    int a = base + k * w + ((wide && big) ? 1 : 0);
    mem[a] = big ? {v[7:0], v[15:8]} : v;
  endtask

  task automatic prepare(int base, int count, bit wide, bit big, logic [15:0] maskV);
    int w = wide ? 2 : 1;
    for (int i = 0; i < 1024; i++) mem[i] = 16'hE000 ^ 16'(i * 7);
    for (int e = 0; e < count; e++) begin
      int eb = base + e * 4 * w;
      putField(eb, 0, 16'(planIdx[e]), wide, big);
      putField(eb, 1, planAddr[e][15:0], wide, big);
      putField(eb, 2, planAddr[e][31:16], wide, big);
      putField(eb, 3, planAddr[e][47:32], wide, big);
      if (planIdx[e] < 16) expTable[planIdx[e]] = planAddr[e];
    end
    putField(base + count * 4 * w, 0, maskV, wide, big);
    expMask = maskV;
  endtask

  task automatic startLoad(int base, int count, bit wide, bit big);
    @(negedge clk);
    reqN = 0;
    descPtr = 16'(base); entryCount = 8'(count); wideSlots = wide; bigOrder = big;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone(string tag);
    int n = 0;
    while (!donePulse && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check("R8", {63'd0, donePulse}, 64'd1, {tag, " done seen"});
    @(negedge clk);
    check("R8", {62'd0, donePulse, busy}, 64'd0, {tag, " done one cycle then idle"});
  endtask

  task automatic verifyAll(string tag, int base, int count, bit wide, bit big);
    int w = wide ? 2 : 1;
    int off = (wide && big) ? 1 : 0;
    int bad = 0;
    for (int i = 0; i < 16; i++) begin
      lookupIdx = 4'(i);
      #1;
      check("R4", {16'd0, lookupAddr}, {16'd0, expTable[i]}, $sformatf("%s slot %0d", tag, i));
    end
    check("R6", {48'd0, enableMask}, {48'd0, expMask}, {tag, " mask"});
    check("R5", 64'(reqN), 64'(count * 4 + 1), {tag, " request count"});
    for (int e = 0; e < count; e++)
      for (int k = 0; k < 4; k++)
        if (reqLog[e * 4 + k] !== 16'(base + e * 4 * w + k * w + off)) bad++;
    if (reqLog[count * 4] !== 16'(base + count * 4 * w + off)) bad++;
    check(big ? "R3" : "R2", 64'(bad), 64'd0, {tag, " request addresses R5 R6"});
  endtask

  task automatic test_reset;
    check("R1", {61'd0, busy, donePulse, memReq}, 64'd0, "control outputs");
    check("R1", {48'd0, enableMask}, 64'd0, "mask");
    for (int i = 0; i < 16; i++) begin
      lookupIdx = 4'(i);
      #1;
      check("R1", {16'd0, lookupAddr}, 64'd0, $sformatf("slot %0d", i));
    end
  endtask

  task automatic runCase(string tag, int base, int count, bit wide, bit big, logic [15:0] maskV);
    prepare(base, count, wide, big, maskV);
    startLoad(base, count, wide, big);
    waitDone(tag);
    verifyAll(tag, base, count, wide, big);
  endtask

  task automatic test_narrow_le;
    planIdx[0] = 0;  planAddr[0] = 48'h0A0B_0C0D_0E0F;
    planIdx[1] = 5;  planAddr[1] = 48'h1122_3344_5566;
    planIdx[2] = 15; planAddr[2] = 48'hFEDC_BA98_7654;
    runCase("narrow-le R2", 16, 3, 1'b0, 1'b0, 16'h8421);
  endtask

  task automatic test_wide_le;
    planIdx[0] = 3; planAddr[0] = 48'h0102_0304_0506;
    planIdx[1] = 7; planAddr[1] = 48'hA1A2_A3A4_A5A6;
    runCase("wide-le R2", 100, 2, 1'b1, 1'b0, 16'h00FF);
  endtask

  task automatic test_wide_be;
    planIdx[0] = 1;  planAddr[0] = 48'h1234_5678_9ABC;
    planIdx[1] = 9;  planAddr[1] = 48'hDEAD_BEEF_0102;
    planIdx[2] = 14; planAddr[2] = 48'h0F0E_0D0C_0B0A;
    runCase("wide-be R3", 200, 3, 1'b1, 1'b1, 16'hC3A5);
  endtask

  task automatic test_narrow_be;
    planIdx[0] = 2; planAddr[0] = 48'h5A5A_A5A5_0110;
    planIdx[1] = 0; planAddr[1] = 48'h7788_99AA_BBCC;
    runCase("narrow-be R3", 300, 2, 1'b0, 1'b1, 16'h1248);
  endtask

  task automatic test_bad_index;
    planIdx[0] = 16;    planAddr[0] = 48'hBAD0_BAD0_BAD0;
    planIdx[1] = 16'h00FF; planAddr[1] = 48'hBAD1_BAD1_BAD1;
    planIdx[2] = 4;     planAddr[2] = 48'h4444_5555_6666;
    runCase("bad-index R7", 400, 3, 1'b1, 1'b0, 16'h0F0F);
  endtask

  task automatic test_zero_count;
    runCase("zero-count R6", 500, 0, 1'b1, 1'b1, 16'h7E57);
  endtask

  task automatic test_busy_start;
    planIdx[0] = 6;  planAddr[0] = 48'hCAFE_F00D_1357;
    planIdx[1] = 11; planAddr[1] = 48'h2468_ACE0_1234;
    prepare(600, 2, 1'b0, 1'b0, 16'h3C3C);
    startLoad(600, 2, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    descPtr = 16'd40; entryCount = 8'd5; wideSlots = 1'b1; bigOrder = 1'b1;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitDone("busy-start R9 R11");
    verifyAll("busy-start R9 R11", 600, 2, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) expTable[i] = '0;
    rstN = 1'b0; startReq = 1'b0; descPtr = '0; entryCount = '0;
    wideSlots = 1'b0; bigOrder = 1'b0; lookupIdx = '0; memRespData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_narrow_le();
    test_wide_le();
    test_wide_be();
    test_narrow_be();
    test_bad_index();
    test_zero_count();
    test_busy_start();
    check("R10", 64'(protoErr), 64'd0, "request while outstanding");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule